// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits on the host side of a byte-wide asynchronous static RAM with 262,144 locations. It takes single-beat read or write requests from a synchronous valid/ready interface and produces the matching bus cycle. The bus cycle uses an 18-bit address, active-low chip, write and output enables, and an 8-bit data bus. The data bus is split into separate out, in and drive-enable signals, so the pad buffer stays outside the block. Each request finishes with a one-cycle done pulse. For reads, the captured byte is valid during that pulse.

Every memory timing limit is a parameter given in nanoseconds. The block converts each limit to clock cycles by rounding up, with a floor of one cycle. The same RTL therefore serves both the 70 ns and the 100 ns speed grades at any system clock. A single down-counter times each phase of the sequence: setup, strobe, hold and recovery.

A power-fail inhibit input has two effects while it is high. It stops new cycles from starting, and it forces every bus strobe inactive.

Top module: `sram_ctrl`

## Requirements
- R1: `req_ready_o` is high only when the controller is idle and `pf_inhibit_i` is low. A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` stays low from acceptance until the recovery phase ends.
- R2: A read (`req_we_i`=0) holds chip enable low from the first cycle after acceptance. Output enable is low for max(ceil(t_acc/T), ceil(t_oe/T)) cycles, which is 4 with the defaults (20 ns clock, 70/35 ns). Write enable stays high for the whole read.
- R3: The byte on `sram_dq_i` during the last output-enable cycle appears on `rsp_rdata_o` while `rsp_done_o` is high. Done comes in the cycle right after output enable rises, which is the 6th cycle after acceptance with the defaults.
- R4: A write (`req_we_i`=1) holds write enable low for max(ceil(t_wp/T), ceil(t_ds/T)) cycles, which is 3 with the defaults. Chip enable is low for one cycle before and one cycle after that strobe. `sram_dq_o` carries the request byte with the driver enabled across those cycles. `rsp_done_o` pulses in the cycle after write enable rises.
- R5: Output enable is never low while write enable is low or while `sram_dq_oe_o` is high. Before a read, the data driver is released at least one cycle before output enable goes low.
- R6: `sram_addr_o` does not change while chip enable stays low.
- R7: After a cycle, chip enable stays high for at least one cycle and for long enough that the full cycle meets the read or write cycle time. With the defaults, `req_ready_o` returns 8 cycles after a read is accepted and 7 cycles after a write is accepted.
- R8: While `pf_inhibit_i` is high, chip, write and output enable are all high, `sram_dq_oe_o` is low, and no new request is accepted. An access already under way still finishes its sequence and pulses `rsp_done_o`.
- R9: `rsp_done_o` lasts exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pf_inhibit_i | input | 1 | Power-fail inhibit; blocks new cycles and forces the strobes inactive |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Byte address |
| req_wdata_i | input | 8 | Write byte |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 8 | Read byte, valid with done |
| sram_addr_o | output | 18 | Memory address bus |
| sram_ce_no | output | 1 | Chip enable, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_dq_o | output | 8 | Data toward memory |
| sram_dq_i | input | 8 | Data from memory |
| sram_dq_oe_o | output | 1 | Drive enable for `sram_dq_o` |

## Verification
The properties assume that the request fields stay stable while `req_valid_i` is high and the request has not yet been accepted. They also assume that `pf_inhibit_i` changes only between clock edges. The bench meets both assumptions: it changes every input on the falling clock edge and leaves the request fields untouched until it sees acceptance. The memory model in the bench answers combinationally whenever chip enable and output enable are both low. It stores a byte on the rising edge of write enable, so read-back checks follow only the bus behaviour.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_RECOVER
  } ph_e;

  // ns -> clock cycles, rounded up, at least one
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cnt.sv
module sram_cnt #(
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          last_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign last_o = (cnt_q == '0);

  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(val_i)));  // R7

endmodule

// File: rtl/sram_fsm.sv
module sram_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CW     = 3,
  parameter int RD_STB = 4,
  parameter int WR_STB = 3,
  parameter int HLD    = 1,
  parameter int RD_REC = 1,
  parameter int WR_REC = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          we_i,
  input  logic          last_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output ph_e           ph_o,
  output logic          wr_o
);

  localparam logic [CW-1:0] L_ONE  = '0;
  localparam logic [CW-1:0] L_RSTB = CW'(RD_STB - 1);
  localparam logic [CW-1:0] L_WSTB = CW'(WR_STB - 1);
  localparam logic [CW-1:0] L_HLD  = CW'(HLD - 1);
  localparam logic [CW-1:0] L_RREC = CW'(RD_REC - 1);
  localparam logic [CW-1:0] L_WREC = CW'(WR_REC - 1);

  ph_e  ph_q, ph_d;
  logic wr_q;

  always_comb begin
    ph_d       = ph_q;
    load_o     = 1'b0;
    load_val_o = L_ONE;
    unique case (ph_q)
      ST_IDLE: if (start_i) begin
        ph_d = ST_SETUP; load_o = 1'b1; load_val_o = L_ONE;
      end
      ST_SETUP: if (last_i) begin
        ph_d = ST_STROBE; load_o = 1'b1; load_val_o = wr_q ? L_WSTB : L_RSTB;
      end
      ST_STROBE: if (last_i) begin
        ph_d = ST_HOLD; load_o = 1'b1; load_val_o = L_HLD;
      end
      ST_HOLD: if (last_i) begin
        ph_d = ST_RECOVER; load_o = 1'b1; load_val_o = wr_q ? L_WREC : L_RREC;
      end
      ST_RECOVER: if (last_i) ph_d = ST_IDLE;
      default: ph_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= ST_IDLE;
      wr_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (start_i && ph_q == ST_IDLE) wr_q <= we_i;
    end
  end

  assign ph_o = ph_q;
  assign wr_o = wr_q;

  AST_START_IN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (ph_q == ST_IDLE));  // R1

  AST_HOLD_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == ST_HOLD) |-> ($past(ph_q) inside {ST_STROBE, ST_HOLD}));  // R9

endmodule

// File: rtl/sram_dp.sv
module sram_dp #(
  parameter int AW = 18,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          smp_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (cap_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (smp_i) rdata_q <= dq_i;
    end
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW     = 18,
  parameter int DW     = 8,
  parameter int CLK_NS = 20,
  parameter int T_ACC  = 70,
  parameter int T_OE   = 35,
  parameter int T_RC   = 70,
  parameter int T_WP   = 55,
  parameter int T_DS   = 30,
  parameter int T_DH   = 10,
  parameter int T_WR   = 5,
  parameter int T_WC   = 70
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pf_inhibit_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_done_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] sram_addr_o,
  output logic          sram_ce_no,
  output logic          sram_we_no,
  output logic          sram_oe_no,
  output logic [DW-1:0] sram_dq_o,
  input  logic [DW-1:0] sram_dq_i,
  output logic          sram_dq_oe_o
);

  localparam int RD_STB = imax(ns2cyc(T_ACC, CLK_NS), ns2cyc(T_OE, CLK_NS));
  localparam int WR_STB = imax(ns2cyc(T_WP, CLK_NS), ns2cyc(T_DS, CLK_NS));
  localparam int HLD    = ns2cyc(T_DH, CLK_NS);
  // setup + strobe + hold already elapsed; recovery fills the rest of the cycle time
  localparam int RD_REC = imax(1, ns2cyc(T_RC, CLK_NS) - (1 + RD_STB + HLD));
  localparam int WR_REC = imax(ns2cyc(T_WR, CLK_NS), ns2cyc(T_WC, CLK_NS) - (1 + WR_STB + HLD));
  localparam int MAXL   = imax(imax(RD_STB, WR_STB), imax(HLD, imax(RD_REC, WR_REC)));
  localparam int CW     = $clog2(MAXL + 1);

  ph_e           ph;
  logic          wr, start, last, load;
  logic [CW-1:0] load_val;
  logic          in_setup, in_strobe, in_hold;

  assign req_ready_o = (ph == ST_IDLE) && !pf_inhibit_i;
  assign start       = req_valid_i && req_ready_o;

  sram_cnt #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (load_val),
    .last_o (last)
  );

  sram_fsm #(
    .CW(CW), .RD_STB(RD_STB), .WR_STB(WR_STB), .HLD(HLD),
    .RD_REC(RD_REC), .WR_REC(WR_REC)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .we_i       (req_we_i),
    .last_i     (last),
    .load_o     (load),
    .load_val_o (load_val),
    .ph_o       (ph),
    .wr_o       (wr)
  );

  assign in_setup  = (ph == ST_SETUP);
  assign in_strobe = (ph == ST_STROBE);
  assign in_hold   = (ph == ST_HOLD);

  sram_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (start),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .smp_i   (in_strobe && last && !wr),
    .dq_i    (sram_dq_i),
    .addr_o  (sram_addr_o),
    .wdata_o (sram_dq_o),
    .rdata_o (rsp_rdata_o)
  );

  // read: CE over setup+strobe; write: CE over setup+strobe+hold (WE-terminated)
  assign sram_ce_no   = pf_inhibit_i || !(in_setup || in_strobe || (in_hold && wr));
  assign sram_we_no   = pf_inhibit_i || !(in_strobe && wr);
  assign sram_oe_no   = pf_inhibit_i || !(in_strobe && !wr);
  assign sram_dq_oe_o = !pf_inhibit_i && wr && (in_setup || in_strobe || in_hold);
  assign rsp_done_o   = in_hold;

  AST_NO_WE_OE_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_we_no && !sram_oe_no));  // R5

  AST_NO_BUS_FIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no);  // R5

  AST_DRV_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_oe_no) |-> !$past(sram_dq_oe_o));  // R5

  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> $stable(sram_addr_o));  // R6

  AST_CE_RECOVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_ce_no) |=> sram_ce_no);  // R7

  AST_PF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_inhibit_i |-> (sram_ce_no && sram_we_no && sram_oe_no && !sram_dq_oe_o && !req_ready_o));  // R8

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);  // R9

  AST_NO_READY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no || rsp_done_o) |-> !req_ready_o);  // R1

endmodule

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pf = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready_o, rsp_done_o, sram_ce_no, sram_we_no, sram_oe_no, sram_dq_oe_o;
  logic [7:0]  rsp_rdata_o, sram_dq_o, sram_dq_i;
  logic [17:0] sram_addr_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] mem [0:255];

  always #10 clk = ~clk;  // 50 MHz

  sram_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .pf_inhibit_i(pf),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_done_o(rsp_done_o), .rsp_rdata_o(rsp_rdata_o),
    .sram_addr_o(sram_addr_o), .sram_ce_no(sram_ce_no), .sram_we_no(sram_we_no),
    .sram_oe_no(sram_oe_no), .sram_dq_o(sram_dq_o), .sram_dq_i(sram_dq_i),
    .sram_dq_oe_o(sram_dq_oe_o)
  );

  // memory model: combinational read, store on rising WE while selected
  assign sram_dq_i = (!sram_ce_no && !sram_oe_no) ? mem[sram_addr_o[7:0]] : 8'hEE;

  always @(posedge sram_we_no)
    if (!sram_ce_no && sram_dq_oe_o) mem[sram_addr_o[7:0]] = sram_dq_o;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_req(input bit we, input logic [17:0] a, input logic [7:0] d,
                         output int r_ce, output int r_we, output int r_oe,
                         output int r_done, output int r_rdy, output int n_done,
                         output logic [7:0] rd, output bit bad_ct, output bit bad_rel,
                         output bit bad_addr);
    logic prev_dqoe;
    int   n;
    r_ce = 0; r_we = 0; r_oe = 0; r_done = -1; r_rdy = -1; n_done = 0;
    rd = '0; bad_ct = 0; bad_rel = 0; bad_addr = 0;
    @(negedge clk);
    req_we = we; req_addr = a; req_wdata = d; req_valid = 1'b1;
    #1;
    while (!req_ready_o) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    prev_dqoe = 1'b0;
    n = 1;
    while (n < 100) begin
      if (!sram_ce_no) r_ce++;
      if (!sram_we_no) r_we++;
      if (!sram_oe_no) r_oe++;
      if (sram_dq_oe_o && !sram_oe_no) bad_ct = 1;
      if (!sram_oe_no && prev_dqoe) bad_rel = 1;
      if (!sram_ce_no && sram_addr_o != a) bad_addr = 1;
      if (we && !sram_we_no && (!sram_dq_oe_o || sram_dq_o != d)) bad_ct = 1;
      if (rsp_done_o) begin r_done = n; rd = rsp_rdata_o; n_done++; end
      if (req_ready_o) begin r_rdy = n; break; end
      prev_dqoe = sram_dq_oe_o;
      n++;
      @(negedge clk); #1;
    end
  endtask

  task automatic t_reset();
    chk(req_ready_o == 1'b1, "R1", "ready after reset", req_ready_o, 1);
    chk({sram_ce_no, sram_we_no, sram_oe_no} == 3'b111, "R8", "strobes idle after reset",
        {sram_ce_no, sram_we_no, sram_oe_no}, 3'b111);
    chk(sram_dq_oe_o == 1'b0, "R5", "driver off after reset", sram_dq_oe_o, 0);
    chk(rsp_done_o == 1'b0, "R9", "no done after reset", rsp_done_o, 0);
  endtask

  task automatic t_read(input logic [17:0] a);
    int ce, we, oe, dn, rdy, nd; logic [7:0] rd; bit bc, br, ba;
    logic [7:0] exp;
    exp = mem[a[7:0]];
    run_req(1'b0, a, 8'h00, ce, we, oe, dn, rdy, nd, rd, bc, br, ba);
    chk(ce == 5, "R2", "read CE low cycles", ce, 5);
    chk(oe == 4, "R2", "read OE low cycles", oe, 4);
    chk(we == 0, "R2", "read WE low cycles", we, 0);
    chk(dn == 6, "R3", "read done cycle", dn, 6);
    chk(rd == exp, "R3", "read data", rd, exp);
    chk(!bc && !br, "R5", "read bus contention/release", {bc, br}, 0);
    chk(!ba, "R6", "read address stable", ba, 0);
    chk(rdy == 8, "R7", "read ready return", rdy, 8);
    chk(nd == 1, "R9", "read done count", nd, 1);
  endtask

  task automatic t_write(input logic [17:0] a, input logic [7:0] d);
    int ce, we, oe, dn, rdy, nd; logic [7:0] rd; bit bc, br, ba;
    run_req(1'b1, a, d, ce, we, oe, dn, rdy, nd, rd, bc, br, ba);
    chk(we == 3, "R4", "write WE low cycles", we, 3);
    chk(ce == 5, "R4", "write CE low cycles", ce, 5);
    chk(oe == 0, "R5", "write OE low cycles", oe, 0);
    chk(!bc, "R4", "write data driven during strobe", bc, 0);
    chk(dn == 5, "R4", "write done cycle", dn, 5);
    chk(!ba, "R6", "write address stable", ba, 0);
    chk(rdy == 7, "R7", "write ready return", rdy, 7);
    chk(nd == 1, "R9", "write done count", nd, 1);
    chk(mem[a[7:0]] == d, "R4", "memory updated", mem[a[7:0]], d);
  endtask

  task automatic t_pf_idle();
    int ce_lo;
    ce_lo = 0;
    @(negedge clk);
    pf = 1'b1; req_valid = 1'b1; req_we = 1'b1; req_addr = 18'h00033; req_wdata = 8'h99;
    #1;
    chk(req_ready_o == 1'b0, "R8", "ready low under inhibit", req_ready_o, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      if (!sram_ce_no || !sram_we_no || sram_dq_oe_o) ce_lo++;
    end
    chk(ce_lo == 0, "R8", "no cycle started under inhibit", ce_lo, 0);
    @(negedge clk);
    req_valid = 1'b0; pf = 1'b0;
    #1;
    chk(mem[8'h33] != 8'h99, "R8", "inhibited write left memory", mem[8'h33], 0);
    chk(req_ready_o == 1'b1, "R1", "ready after inhibit drops", req_ready_o, 1);
  endtask

  task automatic t_pf_midread(input logic [17:0] a);
    int nd, n; bit quiet;
    nd = 0; quiet = 1;
    @(negedge clk);
    req_we = 1'b0; req_addr = a; req_valid = 1'b1;
    #1;
    while (!req_ready_o) begin @(negedge clk); #1; end
    @(negedge clk); req_valid = 1'b0;       // n=1 setup
    @(negedge clk); pf = 1'b1; #1;          // n=2 strobe
    for (n = 2; n < 7; n++) begin
      if (!sram_ce_no || !sram_oe_no || !sram_we_no || sram_dq_oe_o) quiet = 0;
      if (rsp_done_o) nd++;
      @(negedge clk); #1;
    end
    pf = 1'b0;
    chk(quiet, "R8", "strobes forced off mid-read", quiet, 1);
    chk(nd == 1, "R8", "inhibited read still completes", nd, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_all();
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_read(18'h00010);
    t_read(18'h3FF80);
    t_write(18'h00020, 8'hC3);
    t_read(18'h00020);
    t_write(18'h3FFFF, 8'h00);
    t_write(18'h00001, 8'hFF);
    t_read(18'h3FFFF);
    t_read(18'h00001);
    t_pf_idle();
    t_pf_midread(18'h00044);
    t_read(18'h00044);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule